// File: doc/BRIEF.md
# Indirect Parameter RAM Access Port

This block is the single 32-bit host register through which a sample-rate-converter engine reaches its private parameter store: 128 words of 16 bits. One host write carries the RAM address, a write-enable flag, 16 bits of data and a set of control bits that stay in place (a global disable, one freeze flag for each of three channels and three path disables). Reading the register returns the current state of all of these fields.

A host write with write-enable set stores its data word at the given address. A host write with write-enable clear starts a fetch of that address. Each access takes a fixed number of cycles, set by a parameter, and a busy flag is visible in the register for that whole time. After busy drops, the data field holds the fetched word (for a read) or the value that was written (for a write). A host write that arrives while busy is high is dropped completely and sets a sticky protocol-error output, so that a bench can catch drivers that do not poll busy.

Top module: `coef_ram_port`

## Requirements
- R1: After reset the register reads 0x0040_0000. Only the global disable bit (bit 22) is set, busy is 0, and proto_err is 0.
- R2: An accepted host write with bit 24 (write-enable) set stores bits 15:0 into the RAM word addressed by bits 31:25. A later read of that address returns the stored value.
- R3: An accepted host write with bit 24 clear fetches the RAM word addressed by bits 31:25. Once busy has dropped, that word appears in bits 15:0. While the port is idle and no host write arrives, bits 15:0 do not change.
- R4: Busy (bit 23) is set from the clock edge that accepts a request. It stays high for exactly BUSY_CYCLES cycles and then returns to 0.
- R5: The control field (bit 22 global disable; bits 21, 20, 19 freeze for synth, playback and record channels; bits 18, 17, 16 disable for record, playback 2 and playback 1) takes its value from each accepted host write. It keeps that value until the next accepted write, including across the completion of the access.
- R6: A host write while busy is 1 is ignored. The address, control field and RAM contents stay unchanged, and proto_err goes to 1 and stays there until reset.
- R7: Bits 31:25 read back the address of the last accepted request, and bit 24 always reads as 0.
- R8: After a write access completes, bits 15:0 read back the value that was written.
- R9: The lowest (0) and highest (127) RAM addresses can be written and read back like any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Host write strobe for the register, one cycle per write |
| reg_wr_data | input | 32 | Host write value: address, write-enable, control field, data |
| reg_rd_data | output | 32 | Current register view, including busy |
| proto_err | output | 1 | Sticky flag: a host write arrived while busy |

## Verification
On every cycle the assertions check the following: busy rises after each accepted request and lasts exactly BUSY_CYCLES cycles; the address and control fields move only on an accepted write; a write during busy leaves them untouched and raises the sticky error; bit 24 never reads as 1; and the data field stays still while the port is idle. What ends up in the RAM can only be shown by the bench scenarios. These fill all 128 words, read back the boundary addresses, run a seeded random mix of reads and writes against a bench model of the store, and later read a word that a dropped write tried to change.

// File: rtl/coefp_pkg.sv
package coefp_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 16;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int ADDR_LSB = REG_W - ADDR_W;   // address at the top of the word
    localparam int WE_BIT   = ADDR_LSB - 1;
    localparam int BUSY_BIT = WE_BIT - 1;
    localparam int CTL_W    = 7;
    localparam int CTL_LSB  = DATA_W;

    // Packs to bits 22:16 of the register, MSB first.
    typedef struct packed {
        logic       gdis;     // 22 global disable
        logic [2:0] frz;      // 21 synth, 20 playback, 19 record freeze
        logic [2:0] dis;      // 18 record, 17 playback 2, 16 playback 1 disable
    } ctl_t;

    localparam ctl_t CTL_RESET = '{gdis: 1'b1, frz: 3'b000, dis: 3'b000};
endpackage

// File: rtl/coefp_ram.sv
module coefp_ram
    import coefp_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/coefp_seq.sv
module coefp_seq
    import coefp_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              proto_err,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic              err;
        ctl_t              ctl;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t st_d, st_q;
    logic done;
    logic unused_busy_in;

    // Bit 23 of a host write is read-only and has no effect.
    assign unused_busy_in = wr_data[BUSY_BIT];

    always_comb begin
        st_d   = st_q;
        ram_we = 1'b0;
        done   = st_q.busy && (st_q.cnt == '0);

        if (done) begin
            st_d.busy = 1'b0;
            st_d.we   = 1'b0;
            if (st_q.we) begin
                ram_we = 1'b1;
            end else begin
                st_d.data = ram_rdata;
            end
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end

        if (wr_en) begin
            if (st_q.busy) begin
                st_d.err = 1'b1;
            end else begin
                st_d.addr = wr_data[REG_W-1:ADDR_LSB];
                st_d.we   = wr_data[WE_BIT];
                st_d.busy = 1'b1;
                st_d.cnt  = CNT_LOAD;
                st_d.ctl  = ctl_t'(wr_data[CTL_LSB+CTL_W-1:CTL_LSB]);
                st_d.data = wr_data[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{addr: '0, we: 1'b0, busy: 1'b0, cnt: '0, err: 1'b0,
                      ctl: CTL_RESET, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_addr  = st_q.addr;
    assign ram_wdata = st_q.data;
    assign proto_err = st_q.err;
    assign rd_data   = {st_q.addr, 1'b0, st_q.busy, st_q.ctl, st_q.data};
endmodule

// File: rtl/coef_ram_port.sv
module coef_ram_port
    import coefp_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    output logic             proto_err
);
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;

    coefp_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .rd_data   (reg_rd_data),
        .proto_err (proto_err),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata)
    );

    coefp_ram u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );
endmodule

// File: rtl/coef_ram_port_chk.sv
module coef_ram_port_chk
    import coefp_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [REG_W-1:0] reg_wr_data,
    input logic [REG_W-1:0] reg_rd_data,
    input logic             proto_err
);
    localparam int RUN_W = $clog2(BUSY_CYCLES + 1) + 1;

    logic             busy;
    logic [RUN_W-1:0] run_q;
    logic [REG_W-1:0] unused_wr_data;

    assign busy           = reg_rd_data[BUSY_BIT];
    assign unused_wr_data = reg_wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    assert_busy_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !busy) |=> busy);

    assert_busy_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RUN_W'(BUSY_CYCLES)));

    assert_busy_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_q) == RUN_W'(BUSY_CYCLES - 1)));

    assert_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && busy) |=> ($stable(reg_rd_data[REG_W-1:ADDR_LSB])
                                 && $stable(reg_rd_data[CTL_LSB+CTL_W-1:CTL_LSB])
                                 && proto_err));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    assert_ctl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> ($stable(reg_rd_data[CTL_LSB+CTL_W-1:CTL_LSB])
                        && $stable(reg_rd_data[REG_W-1:ADDR_LSB])));

    assert_we_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[WE_BIT] == 1'b0);

    assert_data_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en && !busy) |=> $stable(reg_rd_data[DATA_W-1:0]));
endmodule

bind coef_ram_port coef_ram_port_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .proto_err   (proto_err)
);

// File: tb/coef_ram_port_tb.sv
module coef_ram_port_tb;
    localparam int BC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        proto_err;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem_m [128];
    logic [6:0]  addr_m;
    logic [6:0]  ctl_m;
    logic [15:0] data_m;

    always #10 clk = ~clk;

    coef_ram_port #(.BUSY_CYCLES(BC)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (wr_en),
        .reg_wr_data (wr_data),
        .reg_rd_data (rd_data),
        .proto_err   (proto_err)
    );

    function automatic logic [31:0] mk_req(logic [6:0] a, logic we, logic [6:0] c, logic [15:0] d);
        return {a, we, 1'b0, c, d};
    endfunction

    function automatic logic [31:0] exp_view(logic busy);
        return {addr_m, 1'b0, busy, ctl_m, data_m};
    endfunction

    function automatic logic [15:0] fill_val(int i);
        return 16'((i * 16'h0203) ^ 16'hA55A);
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [6:0] a, logic we, logic [6:0] c, logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = mk_req(a, we, c, d);
        @(negedge clk);
        wr_en  = 1'b0;
        addr_m = a;
        ctl_m  = c;
        data_m = d;
        if (we) mem_m[a] = d;
    endtask

    task automatic wait_done();
        for (int k = 0; k < BC; k++) begin
            check32("R4 busy high", 32'(rd_data[23]), 32'd1);
            @(negedge clk);
        end
        check32("R4 busy low", 32'(rd_data[23]), 32'd0);
    endtask

    task automatic access(string tag, logic [6:0] a, logic we, logic [6:0] c, logic [15:0] d);
        issue(a, we, c, d);
        wait_done();
        if (!we) data_m = mem_m[a];
        check32(tag, rd_data, exp_view(1'b0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        addr_m = '0;
        ctl_m  = 7'h40;
        data_m = '0;

        repeat (3) @(negedge clk);
        check32("R1 reset view", rd_data, 32'h0040_0000);
        check32("R1 reset err", 32'(proto_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R1 after release", rd_data, 32'h0040_0000);

        // R2 R8: fill the whole store
        for (int i = 0; i < 128; i++) begin
            access("R2 R7 R8 fill", 7'(i), 1'b1, 7'(i), fill_val(i));
        end

        // R9: boundary words, R3 read path
        access("R9 R3 read addr 0", 7'd0, 1'b0, 7'h40, 16'hFFFF);
        check32("R9 word 0", 32'(rd_data[15:0]), 32'(fill_val(0)));
        access("R9 R3 read addr 127", 7'd127, 1'b0, 7'h40, 16'h0000);
        check32("R9 word 127", 32'(rd_data[15:0]), 32'(fill_val(127)));
        access("R9 write addr 127", 7'd127, 1'b1, 7'h00, 16'hBEEF);
        access("R9 R2 readback 127", 7'd127, 1'b0, 7'h00, 16'h1234);
        check32("R2 R9 word 127", 32'(rd_data[15:0]), 32'h0000_BEEF);

        // R5: control field held while idle
        access("R5 all control bits", 7'd33, 1'b0, 7'h7F, 16'h0);
        repeat (10) @(negedge clk);
        check32("R5 R3 held while idle", rd_data, exp_view(1'b0));
        access("R5 control cleared", 7'd34, 1'b1, 7'h15, 16'h5A5A);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [6:0]  ra = 7'($urandom);
            logic        rw = 1'($urandom);
            logic [6:0]  rc = 7'($urandom);
            logic [15:0] rd = 16'($urandom);
            access(rw ? "R2 R5 R8 random write" : "R3 R5 R7 random read", ra, rw, rc, rd);
        end
        check32("R6 no error yet", 32'(proto_err), 32'd0);

        // R6: write during busy is dropped
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = mk_req(7'd5, 1'b1, 7'h2A, 16'h1111);
        @(negedge clk);
        wr_data = mk_req(7'd9, 1'b1, 7'h55, 16'h2222);
        @(negedge clk);
        wr_en = 1'b0;
        addr_m = 7'd5; ctl_m = 7'h2A; data_m = 16'h1111; mem_m[5] = 16'h1111;
        repeat (BC) @(negedge clk);
        check32("R6 fields kept", rd_data, exp_view(1'b0));
        check32("R6 error set", 32'(proto_err), 32'd1);
        access("R6 word 9 untouched", 7'd9, 1'b0, 7'h01, 16'h0);
        access("R6 R2 word 5 written", 7'd5, 1'b0, 7'h01, 16'h0);
        check32("R6 error sticky", 32'(proto_err), 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule